// File: doc/BRIEF.md
# Subframe Chip-Count Timing Generator

This block paces a spread-chip serial modem. A free-running chip counter moves one step on every clock where the chip-rate enable is high. It spans 2880 chips, which is one physical subframe, and then wraps. Registered strobes are decoded from the counter and pace bit, byte and frame transfer. There are also early-warning strobes that come one bit period (eight chips) ahead of every byte and frame boundary. The embedded processor takes these early strobes as interrupts, so it can prepare the next byte or frame in time.

A pre-slot level spans the gap between the early-frame warning and the frame boundary. An external host can watch this level on a shared output pin to line its software up with the subframe. A single configuration input chooses what the pin carries: the pre-slot level or transmit data. The transmit/receive mode flag has no effect on the counter, so the strobes keep the same relative timing in both directions.

All strobe outputs change only on a clock edge where the enable is high. After that edge they describe the chip that the tick began, and `chip_cnt_o` gives the number of that chip. On any edge without an enable the strobes return low.

Top module: `subframe_timer`

## Requirements
- R1: The internal count starts at 0 after reset and advances by one per enabled tick. After 2879 it wraps to 0. After each enabled edge, `chip_cnt_o` holds the count of the chip that tick began, so the first tick after reset reports 0.
- R2: `bit_stb_o` is high after a tick exactly when the ticked count is a multiple of 8, which gives 360 pulses per subframe.
- R3: `byte_stb_o` is high after a tick exactly when the ticked count is a multiple of 64, which gives 45 pulses per subframe.
- R4: `frame_stb_o` is high after a tick only when the ticked count is 0, which gives one pulse per subframe.
- R5: `pre_byte_stb_o` is high after a tick exactly when the ticked count modulo 64 equals 56. This covers 56, 120, … 2808 and also 2872, the warning for the byte at count 0 after the wrap.
- R6: `pre_frame_stb_o` is high after a tick only when the ticked count is 2872.
- R7: `preslot_o` goes high together with `pre_frame_stb_o` and stays high until it falls together with `frame_stb_o`. It is low otherwise, and low after reset.
- R8: Changing `txmode_i` does not reset, pause or skip the count or any strobe.
- R9: While `pin_sel_i` is 0 (configuration bit 7 cleared), `pin_o` carries `preslot_o`. While it is 1, `pin_o` carries `tx_data_i`. The pin is combinational.
- R10: A clock edge where `chip_en_i` is low keeps the count and `chip_cnt_o` unchanged and drives every strobe low. Each strobe is therefore at most one clock wide per enabled tick.
- R11: A synchronous active-high `rst_i` clears the count, `chip_cnt_o`, all strobes and `preslot_o`, and overrides `chip_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| chip_en_i | input | 1 | Chip-rate tick enable |
| txmode_i | input | 1 | Transmit (1) / receive (0) mode flag |
| pin_sel_i | input | 1 | Configuration bit 7: 0 selects pre-slot, 1 selects transmit data for the pin |
| tx_data_i | input | 1 | Transmit data for the shared pin |
| chip_cnt_o | output | 12 | Count of the chip begun by the last enabled tick |
| bit_stb_o | output | 1 | Bit boundary strobe |
| byte_stb_o | output | 1 | Byte boundary strobe |
| frame_stb_o | output | 1 | Subframe start strobe |
| pre_byte_stb_o | output | 1 | Early byte warning, eight chips ahead |
| pre_frame_stb_o | output | 1 | Early frame warning, eight chips ahead |
| preslot_o | output | 1 | Pre-slot window level |
| pin_o | output | 1 | Shared output pin |

## Verification
The assertions assume that `rst_i` is held for at least one edge before any check counts, and that the mode flag and the enable are clean synchronous levels that may change on any cycle. The wrap and mode checks also assume that the enable alone gates advancement, with no other input allowed to stall the counter. The stimulus keeps to these assumptions. It first runs full subframes with a steady enable while the mode flips at intervals unrelated to the subframe length. It then moves to random enable gaps together with random mode, pin-select and data values. Last comes a reset in the middle of a subframe while the enable is held high, which shows that reset wins over the enable.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;

    typedef struct packed {
        logic bit_s;
        logic byte_s;
        logic frame_s;
        logic pre_byte_s;
        logic pre_frame_s;
    } strb_t;

endpackage

// File: rtl/sft_chip_counter.sv
`timescale 1ns/1ps
module sft_chip_counter #(
    parameter int FRAME_CHIPS = 2880,
    parameter int CW          = $clog2(FRAME_CHIPS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CHIPS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R1: count never leaves the subframe range
    a_r1_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);

    // R1: last chip is followed by chip 0
    a_r1_wraps: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && cnt_q == LAST) |=> (cnt_q == '0));

    // R10: no tick, no movement
    a_r10_holds: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/sft_strobe_decode.sv
`timescale 1ns/1ps
module sft_strobe_decode
    import sft_pkg::*;
#(
    parameter int FRAME_CHIPS   = 2880,
    parameter int CHIPS_PER_BIT = 8,
    parameter int BITS_PER_BYTE = 8,
    parameter int CW            = $clog2(FRAME_CHIPS)
) (
    input  logic [CW-1:0] cnt_i,
    output strb_t         strb_o
);
    localparam int BIT_LG  = $clog2(CHIPS_PER_BIT);
    localparam int BYTE_LG = BIT_LG + $clog2(BITS_PER_BYTE);
    localparam logic [CW-1:0] LEAD   = CW'(CHIPS_PER_BIT);
    localparam logic [CW-1:0] TURN   = CW'(FRAME_CHIPS - CHIPS_PER_BIT);

    logic [CW-1:0] ahead;

    always_comb begin
        // count one bit period later, folded across the subframe wrap
        ahead = (cnt_i >= TURN) ? cnt_i - TURN : cnt_i + LEAD;

        strb_o.bit_s       = (cnt_i[BIT_LG-1:0]  == '0);
        strb_o.byte_s      = (cnt_i[BYTE_LG-1:0] == '0);
        strb_o.frame_s     = (cnt_i == '0);
        strb_o.pre_byte_s  = (ahead[BYTE_LG-1:0] == '0);
        strb_o.pre_frame_s = (ahead == '0);
    end

endmodule

// File: rtl/subframe_timer.sv
`timescale 1ns/1ps
module subframe_timer
    import sft_pkg::*;
#(
    parameter int FRAME_CHIPS   = 2880,
    parameter int CHIPS_PER_BIT = 8,
    parameter int BITS_PER_BYTE = 8,
    localparam int CW           = $clog2(FRAME_CHIPS)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          chip_en_i,
    input  logic          txmode_i,
    input  logic          pin_sel_i,
    input  logic          tx_data_i,
    output logic [CW-1:0] chip_cnt_o,
    output logic          bit_stb_o,
    output logic          byte_stb_o,
    output logic          frame_stb_o,
    output logic          pre_byte_stb_o,
    output logic          pre_frame_stb_o,
    output logic          preslot_o,
    output logic          pin_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CHIPS - 1);

    typedef struct packed {
        logic [CW-1:0] chip;
        strb_t         strb;
        logic          preslot;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] next_cnt;
    strb_t         dec;

    sft_chip_counter #(
        .FRAME_CHIPS(FRAME_CHIPS),
        .CW         (CW)
    ) u_cnt (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .en_i (chip_en_i),
        .cnt_o(next_cnt)
    );

    sft_strobe_decode #(
        .FRAME_CHIPS  (FRAME_CHIPS),
        .CHIPS_PER_BIT(CHIPS_PER_BIT),
        .BITS_PER_BYTE(BITS_PER_BYTE),
        .CW           (CW)
    ) u_dec (
        .cnt_i (next_cnt),
        .strb_o(dec)
    );

    always_comb begin
        st_d      = st_q;
        st_d.strb = '0;
        if (chip_en_i) begin
            st_d.chip = next_cnt;
            st_d.strb = dec;
            if (dec.pre_frame_s)  st_d.preslot = 1'b1;
            else if (dec.frame_s) st_d.preslot = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign chip_cnt_o      = st_q.chip;
    assign bit_stb_o       = st_q.strb.bit_s;
    assign byte_stb_o      = st_q.strb.byte_s;
    assign frame_stb_o     = st_q.strb.frame_s;
    assign pre_byte_stb_o  = st_q.strb.pre_byte_s;
    assign pre_frame_stb_o = st_q.strb.pre_frame_s;
    assign preslot_o       = st_q.preslot;
    assign pin_o           = pin_sel_i ? tx_data_i : st_q.preslot;

    // R10: an idle edge leaves every strobe low
    a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !chip_en_i |=> (st_q.strb == '0));

    // R3: a byte boundary is always a bit boundary
    a_r3_byte_on_bit: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_stb_o |-> bit_stb_o);

    // R4: the frame boundary is a byte boundary at chip 0
    a_r4_frame_at_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_stb_o |-> (byte_stb_o && chip_cnt_o == '0));

    // R6: the early frame warning coincides with an early byte warning
    a_r6_preframe_prebyte: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_frame_stb_o |-> pre_byte_stb_o);

    // R7: window opens with the early frame warning
    a_r7_preslot_open: assert property (@(posedge clk_i) disable iff (rst_i)
        pre_frame_stb_o |-> preslot_o);

    // R7: window is closed at the frame boundary
    a_r7_preslot_shut: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_stb_o |-> !preslot_o);

    // R8: a mode change on a tick still advances the count by exactly one
    a_r8_mode_transparent: assert property (@(posedge clk_i) disable iff (rst_i)
        (chip_en_i && (txmode_i != $past(txmode_i)))
        |=> (next_cnt == (($past(next_cnt) == LAST) ? '0 : $past(next_cnt) + 1'b1)));

endmodule

// File: tb/tb_subframe_timer.sv
`timescale 1ns/1ps
module tb_subframe_timer;
    localparam int FC = 2880;

    logic        clk = 1'b0;
    logic        rst, en, mode, sel, tx;
    logic [11:0] chip_cnt;
    logic        b_s, y_s, f_s, pb_s, pf_s, pre, pin;

    always #4 clk = ~clk;

    subframe_timer dut (
        .clk_i(clk), .rst_i(rst), .chip_en_i(en), .txmode_i(mode),
        .pin_sel_i(sel), .tx_data_i(tx),
        .chip_cnt_o(chip_cnt), .bit_stb_o(b_s), .byte_stb_o(y_s),
        .frame_stb_o(f_s), .pre_byte_stb_o(pb_s), .pre_frame_stb_o(pf_s),
        .preslot_o(pre), .pin_o(pin)
    );

    int checks = 0, errors = 0;
    int m_next = 0, m_chip = 0;
    bit m_b, m_y, m_f, m_pb, m_pf, m_pre;
    bit m_rst_tag, m_mchg_tag, prev_mode, live = 0;
    int tally_n = 0, t_b, t_y, t_f, t_pb, t_pf;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        string cnt_tag;
        cnt_tag = m_rst_tag ? "R11 count" : (m_mchg_tag ? "R8 count" : "R1 count");
        chk(cnt_tag, int'(chip_cnt), m_chip);
        chk("R2 bit strobe", int'(b_s), int'(m_b));
        chk("R3 byte strobe", int'(y_s), int'(m_y));
        chk("R4 frame strobe", int'(f_s), int'(m_f));
        chk("R5 early byte", int'(pb_s), int'(m_pb));
        chk("R6 early frame", int'(pf_s), int'(m_pf));
        chk(m_rst_tag ? "R11 preslot" : "R7 preslot", int'(pre), int'(m_pre));
        chk("R9 pin", int'(pin), int'(sel ? tx : m_pre));
        if (tally_n > 0) begin
            t_b += int'(b_s); t_y += int'(y_s); t_f += int'(f_s);
            t_pb += int'(pb_s); t_pf += int'(pf_s);
            tally_n--;
        end
    endtask

    task automatic step(input bit r, input bit e, input bit m, input bit s, input bit t);
        int c, a;
        @(negedge clk);
        if (live) compare();
        live = 1;
        rst = r; en = e; mode = m; sel = s; tx = t;
        m_mchg_tag = e && (m != prev_mode);
        prev_mode  = m;
        m_rst_tag  = r;
        if (r) begin
            m_next = 0; m_chip = 0; m_pre = 0;
            {m_b, m_y, m_f, m_pb, m_pf} = '0;
        end else if (e) begin
            c = m_next;
            a = (c + 8) % FC;
            m_chip = c;
            m_b  = (c % 8 == 0);
            m_y  = (c % 64 == 0);
            m_f  = (c == 0);
            m_pb = (a % 64 == 0);
            m_pf = (a == 0);
            if (m_pf)     m_pre = 1;
            else if (m_f) m_pre = 0;
            m_next = (c + 1) % FC;
        end else begin
            {m_b, m_y, m_f, m_pb, m_pf} = '0;
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit md;
        {rst, en, mode, sel, tx} = 5'b10000;
        // R11: reset, with enable high to show reset wins
        step(1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        // steady enable, mode flips at an unrelated interval (R8)
        md = 0;
        step(0, 1, md, 0, 0);
        tally_n = FC;
        t_b = 0; t_y = 0; t_f = 0; t_pb = 0; t_pf = 0;
        for (int i = 1; i < 2 * FC + 40; i++) begin
            if (i % 997 == 0) md = ~md;
            step(0, 1, md, 0, 0);
        end
        // per-subframe pulse tallies (R2..R6)
        chk("R2 bits per subframe", t_b, 360);
        chk("R3 bytes per subframe", t_y, 45);
        chk("R4 frames per subframe", t_f, 1);
        chk("R5 early bytes per subframe", t_pb, 45);
        chk("R6 early frames per subframe", t_pf, 1);
        // R10: random enable gaps, random mode, pin select and data
        for (int i = 0; i < 2 * FC + 300; i++) begin
            step(0, ($urandom_range(2) != 0), 1'($urandom_range(1)),
                 1'($urandom_range(1)), 1'($urandom_range(1)));
        end
        // R11: mid-subframe reset while enabled, then pin carries data (R9)
        step(1, 1, 1, 1, 1);
        step(1, 1, 0, 1, 0);
        for (int i = 0; i < FC + 100; i++) begin
            step(0, 1, 1'(i / 500), 1, 1'($urandom_range(1)));
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        finish_run();
    end

endmodule